// File: doc/BRIEF.md
# Shared Packet Buffer Pipe Arbiter

This block arbitrates a packet buffer that a host CPU and a serial interface engine share. The buffer is cut into 64-byte blocks. Each of eight pipes owns a run of whole blocks, given by a start block number and a size code. The size code holds the block count minus one. Three CPU-side FIFO ports each choose a pipe at run time. Each port produces a byte address inside its pipe's region, and the address steps by one for every accepted CPU access.

For each pipe, a two-state machine records which side holds the buffer. In `OWN_CPU` the CPU may read or write it. The *hand-off* transition moves the pipe to `OWN_SIE`. It fires when a CPU access lands on the last byte of the region, or when the CPU commits the buffer early. The *release* transition returns the pipe to `OWN_CPU` when the engine pulses its done line for that pipe. A port's ready flag tells software when it may touch the buffer. Accesses made while a port is not ready are dropped and leave a sticky error bit.

Top module: `pipe_buf_arbiter`

## Requirements
- R1: After reset, every pipe is in `OWN_CPU`, every start and size code is 0, every port selects pipe 0 at offset 0, and every error bit is clear. Only port 0 is ready, because ports 1 and 2 share pipe 0 with it.
- R2: A cycle with `cfg_we` high loads `cfg_start` and `cfg_size` into pipe `cfg_pipe` only if that pipe is in `OWN_CPU`. While the pipe is in `OWN_SIE` the write is ignored.
- R3: A port's address is the selected pipe's start block times 64 plus the port's offset, kept to ADDR_W bits. A region spans (size code + 1) × 64 bytes.
- R4: A cycle with `sel_we[i]` high loads port i's pipe selection from its `sel_val` slice and clears its offset. Any access or commit on port i in that cycle is dropped without an error.
- R5: An access on a ready port, when it is not the last byte of the region and there is no commit, raises the port's offset by one.
- R6: An access on a ready port at offset (size+1)×64−1 takes the hand-off transition. The pipe goes to `OWN_SIE`, and the offset of every port selecting that pipe returns to 0.
- R7: A commit on a ready port takes the hand-off transition whatever the offset is. A commit outranks an access in the same cycle, so the offset does not advance.
- R8: A `sie_done` pulse for a pipe in `OWN_SIE` takes the release transition and clears the offsets of the ports on that pipe. A `sie_done` pulse for a pipe in `OWN_CPU` has no effect.
- R9: A port is ready only when its pipe is in `OWN_CPU` and no lower-numbered port selects the same pipe.
- R10: An access or commit on a port that is not ready changes no offset and no ownership. It sets that port's error bit, which stays set until reset.
- R11: `sie_own[p]` is 1 exactly while pipe p is in `OWN_SIE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_pipe | input | PIPE_W | Pipe whose region is written |
| cfg_start | input | BLK_W | Start block number |
| cfg_size | input | SIZE_W | Block count minus one |
| sel_we | input | NUM_PORTS | Per-port pipe selection write |
| sel_val | input | NUM_PORTS*PIPE_W | Per-port new pipe number, port i in slice i |
| acc | input | NUM_PORTS | Per-port one-byte CPU access strobe |
| commit | input | NUM_PORTS | Per-port early buffer hand-off |
| sie_done | input | NUM_PIPES | Per-pipe engine finished pulse |
| ready | output | NUM_PORTS | Per-port CPU access permitted |
| addr | output | NUM_PORTS*ADDR_W | Per-port byte address, port i in slice i |
| err | output | NUM_PORTS | Per-port sticky refused-access flag |
| sie_own | output | NUM_PIPES | Per-pipe buffer status, 1 = engine side |

## Verification
The assertions check the cycle-local rules on every clock:
- error bits never clear once set;
- a selection write zeroes the offset;
- an accepted mid-region access advances the offset by one;
- a commit on a ready port lands the pipe in `OWN_SIE`;
- a pipe in `OWN_SIE` keeps its region and its owner until its done pulse.

Only the bench scenarios can show the rest:
- the exact address values;
- the fill point at the end of a one-block region;
- port precedence when two ports share a pipe, and ready returning once the lower port moves away;
- the fact that configuration refused during `OWN_SIE` is still absent after the release.

// File: rtl/pba_pkg.sv
package pba_pkg;
    typedef enum logic {
        OWN_CPU = 1'b0,
        OWN_SIE = 1'b1
    } owner_e;
endpackage

// File: rtl/pba_owner_fsm.sv
module pba_owner_fsm
    import pba_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic give_i,
    input  logic done_i,
    output logic sie_own_o,
    output logic flip_o
);
    owner_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OWN_CPU;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_CPU: if (give_i) state_d = OWN_SIE;
            OWN_SIE: if (done_i) state_d = OWN_CPU;
        endcase
    end

    always_comb begin
        sie_own_o = (state_q == OWN_SIE);
        flip_o    = (state_q != state_d);
    end
endmodule

// File: rtl/pba_region_regs.sv
module pba_region_regs #(
    parameter int NUM_PIPES = 8,
    parameter int PIPE_W    = 3,
    parameter int BLK_W     = 5,
    parameter int SIZE_W    = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [PIPE_W-1:0]                    cfg_pipe,
    input  logic [BLK_W-1:0]                     cfg_start,
    input  logic [SIZE_W-1:0]                    cfg_size,
    input  logic [NUM_PIPES-1:0]                 sie_own,
    output logic [NUM_PIPES-1:0][BLK_W-1:0]      start_o,
    output logic [NUM_PIPES-1:0][SIZE_W-1:0]     size_o
);
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_o[p] <= '0;
                size_o[p]  <= '0;
            end else if (cfg_we && cfg_pipe == PIPE_W'(p) && !sie_own[p]) begin
                start_o[p] <= cfg_start;
                size_o[p]  <= cfg_size;
            end
        end
    end
endmodule

// File: rtl/pba_port.sv
module pba_port #(
    parameter int PIPE_W = 3,
    parameter int BLK_W  = 5,
    parameter int SIZE_W = 3,
    parameter int OFS_LO = 6,
    localparam int OFF_W  = SIZE_W + OFS_LO,
    localparam int ADDR_W = BLK_W + OFS_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [PIPE_W-1:0] sel_val,
    input  logic              acc,
    input  logic              commit,
    input  logic              ready,
    input  logic [BLK_W-1:0]  start,
    input  logic [SIZE_W-1:0] size,
    input  logic              flip,
    output logic [PIPE_W-1:0] cur_sel_o,
    output logic [OFF_W-1:0]  off_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o,
    output logic              handoff_o,
    output logic              err_o
);
    logic acc_ok, cmt_ok, refused;

    always_comb begin
        acc_ok    = acc && ready && !sel_we;
        cmt_ok    = commit && ready && !sel_we;
        refused   = (acc || commit) && !ready && !sel_we;
        last_o    = (off_o == {size, {OFS_LO{1'b1}}});
        handoff_o = cmt_ok || (acc_ok && last_o);
        addr_o    = {start, {OFS_LO{1'b0}}} + ADDR_W'(off_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_sel_o <= '0;
            off_o     <= '0;
            err_o     <= 1'b0;
        end else begin
            if (refused) err_o <= 1'b1;
            if (sel_we) begin
                cur_sel_o <= sel_val;
                off_o     <= '0;
            end else if (flip) begin
                off_o <= '0;
            end else if (acc_ok && !commit) begin
                off_o <= off_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pipe_buf_arbiter.sv
module pipe_buf_arbiter #(
    parameter int NUM_PIPES = 8,
    parameter int NUM_PORTS = 3,
    parameter int BLK_W     = 5,
    parameter int SIZE_W    = 3,
    parameter int BLK_BYTES = 64,
    localparam int PIPE_W   = $clog2(NUM_PIPES),
    localparam int OFS_LO   = $clog2(BLK_BYTES),
    localparam int OFF_W    = SIZE_W + OFS_LO,
    localparam int ADDR_W   = BLK_W + OFS_LO
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [PIPE_W-1:0]             cfg_pipe,
    input  logic [BLK_W-1:0]              cfg_start,
    input  logic [SIZE_W-1:0]             cfg_size,
    input  logic [NUM_PORTS-1:0]          sel_we,
    input  logic [NUM_PORTS*PIPE_W-1:0]   sel_val,
    input  logic [NUM_PORTS-1:0]          acc,
    input  logic [NUM_PORTS-1:0]          commit,
    input  logic [NUM_PIPES-1:0]          sie_done,
    output logic [NUM_PORTS-1:0]          ready,
    output logic [NUM_PORTS*ADDR_W-1:0]   addr,
    output logic [NUM_PORTS-1:0]          err,
    output logic [NUM_PIPES-1:0]          sie_own
);
    logic [NUM_PIPES-1:0][BLK_W-1:0]  start_all;
    logic [NUM_PIPES-1:0][SIZE_W-1:0] size_all;
    logic [NUM_PIPES-1:0]             give, flip;
    logic [NUM_PORTS-1:0][PIPE_W-1:0] cur_sel;
    logic [NUM_PORTS-1:0][OFF_W-1:0]  off;
    logic [NUM_PORTS-1:0]             last, handoff;

    pba_region_regs #(
        .NUM_PIPES(NUM_PIPES), .PIPE_W(PIPE_W), .BLK_W(BLK_W), .SIZE_W(SIZE_W)
    ) u_regions (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pipe(cfg_pipe),
        .cfg_start(cfg_start), .cfg_size(cfg_size), .sie_own(sie_own),
        .start_o(start_all), .size_o(size_all)
    );

    always_comb begin
        give = '0;
        for (int i = 0; i < NUM_PORTS; i++)
            if (handoff[i]) give[cur_sel[i]] = 1'b1;
    end

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_owner
        pba_owner_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .give_i(give[p]), .done_i(sie_done[p]),
            .sie_own_o(sie_own[p]), .flip_o(flip[p])
        );
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        logic shadowed;
        always_comb begin
            shadowed = 1'b0;
            for (int j = 0; j < i; j++)
                if (cur_sel[j] == cur_sel[i]) shadowed = 1'b1;
            ready[i] = !sie_own[cur_sel[i]] && !shadowed;
        end

        pba_port #(
            .PIPE_W(PIPE_W), .BLK_W(BLK_W), .SIZE_W(SIZE_W), .OFS_LO(OFS_LO)
        ) u_port (
            .clk(clk), .rst_n(rst_n), .sel_we(sel_we[i]),
            .sel_val(sel_val[i*PIPE_W +: PIPE_W]), .acc(acc[i]), .commit(commit[i]),
            .ready(ready[i]), .start(start_all[cur_sel[i]]), .size(size_all[cur_sel[i]]),
            .flip(flip[cur_sel[i]]), .cur_sel_o(cur_sel[i]), .off_o(off[i]),
            .addr_o(addr[i*ADDR_W +: ADDR_W]), .last_o(last[i]),
            .handoff_o(handoff[i]), .err_o(err[i])
        );
    end
endmodule

// File: rtl/pba_checker.sv
module pba_checker #(
    parameter int NUM_PIPES = 8,
    parameter int NUM_PORTS = 3,
    parameter int PIPE_W    = 3,
    parameter int BLK_W     = 5,
    parameter int OFF_W     = 9
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_PORTS-1:0]             sel_we,
    input logic [NUM_PORTS-1:0]             acc,
    input logic [NUM_PORTS-1:0]             commit,
    input logic [NUM_PORTS-1:0]             ready,
    input logic [NUM_PORTS-1:0]             err,
    input logic [NUM_PIPES-1:0]             sie_own,
    input logic [NUM_PIPES-1:0]             sie_done,
    input logic [NUM_PORTS-1:0][PIPE_W-1:0] cur_sel,
    input logic [NUM_PORTS-1:0][OFF_W-1:0]  off,
    input logic [NUM_PORTS-1:0]             last,
    input logic [NUM_PIPES-1:0][BLK_W-1:0]  start_all
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port_chk
        assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            err[i] |=> err[i]);
        assert_sel_clears_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
            sel_we[i] |=> off[i] == '0);
        assert_offset_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ready[i] && acc[i] && !commit[i] && !sel_we[i] && !last[i])
            |=> off[i] == $past(off[i]) + 1'b1);
        assert_commit_hands_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ready[i] && commit[i] && !sel_we[i]) |=> sie_own[$past(cur_sel[i])]);
    end

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe_chk
        assert_sie_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (sie_own[p] && !sie_done[p]) |=> sie_own[p]);
        assert_region_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
            sie_own[p] |=> $stable(start_all[p]));
    end
endmodule

bind pipe_buf_arbiter pba_checker #(
    .NUM_PIPES(NUM_PIPES), .NUM_PORTS(NUM_PORTS), .PIPE_W(PIPE_W),
    .BLK_W(BLK_W), .OFF_W(OFF_W)
) u_pba_checker (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .acc(acc), .commit(commit),
    .ready(ready), .err(err), .sie_own(sie_own), .sie_done(sie_done),
    .cur_sel(cur_sel), .off(off), .last(last), .start_all(start_all)
);

// File: tb/pipe_buf_arbiter_bench.sv
module pipe_buf_arbiter_bench;
    localparam int NP = 8, NQ = 3, PW = 3, AW = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0;
    logic [PW-1:0] cfg_pipe = 0;
    logic [4:0] cfg_start = 0;
    logic [2:0] cfg_size = 0;
    logic [NQ-1:0] sel_we = 0, acc = 0, commit = 0;
    logic [NQ*PW-1:0] sel_val = 0;
    logic [NP-1:0] sie_done = 0;
    logic [NQ-1:0] ready, err;
    logic [NQ*AW-1:0] addr;
    logic [NP-1:0] sie_own;

    always #2 clk = ~clk;

    pipe_buf_arbiter u_pipe_buf_arbiter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pipe(cfg_pipe),
        .cfg_start(cfg_start), .cfg_size(cfg_size), .sel_we(sel_we), .sel_val(sel_val),
        .acc(acc), .commit(commit), .sie_done(sie_done), .ready(ready), .addr(addr),
        .err(err), .sie_own(sie_own)
    );

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;
    int m_start[NP], m_size[NP], m_sie[NP];
    int m_sel[NQ], m_off[NQ], m_err[NQ];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_ready(input int i);
        if (m_sie[m_sel[i]] != 0) return 0;
        for (int j = 0; j < i; j++) if (m_sel[j] == m_sel[i]) return 0;
        return 1;
    endfunction

    function automatic int port_addr(input int i);
        return int'(addr[i*AW +: AW]);
    endfunction

    task automatic compare();
        int own;
        own = 0;
        for (int p = 0; p < NP; p++) own |= (m_sie[p] << p);
        for (int i = 0; i < NQ; i++) begin
            check(ready[i] == m_ready(i), "R9 ready", ready[i], m_ready(i));
            check(port_addr(i) == (m_start[m_sel[i]] * 64 + m_off[i]) % 2048, "R3 addr",
                  port_addr(i), (m_start[m_sel[i]] * 64 + m_off[i]) % 2048);
            check(err[i] == m_err[i], "R10 err", err[i], m_err[i]);
        end
        check(int'(sie_own) == own, "R11 sie_own", sie_own, own);
    endtask

    task automatic model_update();
        int give[NP], flip[NP], inc[NQ], rdy[NQ];
        for (int p = 0; p < NP; p++) give[p] = 0;
        for (int i = 0; i < NQ; i++) begin
            rdy[i] = m_ready(i);
            inc[i] = 0;
        end
        for (int i = 0; i < NQ; i++) begin
            if (sel_we[i]) continue;
            if ((acc[i] || commit[i]) && rdy[i] == 0) m_err[i] = 1;
            else if (commit[i]) give[m_sel[i]] = 1;
            else if (acc[i]) begin
                if (m_off[i] == (m_size[m_sel[i]] + 1) * 64 - 1) give[m_sel[i]] = 1;
                else inc[i] = 1;
            end
        end
        for (int p = 0; p < NP; p++)
            flip[p] = (m_sie[p] == 0) ? give[p] : int'(sie_done[p]);
        if (cfg_we && m_sie[cfg_pipe] == 0) begin
            m_start[cfg_pipe] = cfg_start;
            m_size[cfg_pipe]  = cfg_size;
        end
        for (int i = 0; i < NQ; i++) begin
            if (sel_we[i]) begin
                m_sel[i] = sel_val[i*PW +: PW];
                m_off[i] = 0;
            end else if (flip[m_sel[i]] != 0) m_off[i] = 0;
            else if (inc[i] != 0) m_off[i]++;
        end
        for (int p = 0; p < NP; p++) if (flip[p] != 0) m_sie[p] = 1 - m_sie[p];
    endtask

    task automatic tick();
        compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        cfg_we = 0; sel_we = 0; acc = 0; commit = 0; sie_done = 0;
    endtask

    task automatic cfg(input int p, input int s, input int z);
        cfg_we = 1; cfg_pipe = PW'(p); cfg_start = 5'(s); cfg_size = 3'(z);
        tick();
    endtask

    task automatic sel(input int i, input int p);
        sel_we[i] = 1; sel_val[i*PW +: PW] = PW'(p);
    endtask

    task automatic access(input int i, input int n);
        for (int k = 0; k < n; k++) begin
            acc[i] = 1;
            tick();
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done_flag) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin m_start[p] = 0; m_size[p] = 0; m_sie[p] = 0; end
        for (int i = 0; i < NQ; i++) begin m_sel[i] = 0; m_off[i] = 0; m_err[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check(ready == 3'b001, "R1 ready", ready, 1);
        check(err == 0, "R1 err", err, 0);
        check(sie_own == 0, "R1 sie_own", sie_own, 0);
        check(addr == 0, "R1 addr", addr, 0);
        tick();

        cfg(1, 4, 0); cfg(3, 6, 1); cfg(5, 10, 3);
        sel(0, 1); sel(1, 3); sel(2, 5); tick();
        check(port_addr(1) == 384, "R3 port1 base", port_addr(1), 384);
        check(port_addr(2) == 640, "R2 port2 base", port_addr(2), 640);

        access(1, 5);
        check(port_addr(1) == 389, "R5 step", port_addr(1), 389);

        access(0, 64);
        check(sie_own[1] == 1, "R6 fill handoff", sie_own[1], 1);
        check(port_addr(0) == 256, "R6 offset cleared", port_addr(0), 256);

        access(0, 1);
        check(err[0] == 1, "R10 refused access", err[0], 1);
        check(port_addr(0) == 256, "R10 no advance", port_addr(0), 256);

        cfg(1, 20, 2);
        sie_done[3] = 1; tick();
        check(sie_own[3] == 0, "R8 done on cpu pipe", sie_own[3], 0);
        check(port_addr(1) == 389, "R8 cpu pipe offset kept", port_addr(1), 389);
        sie_done[1] = 1; tick();
        check(sie_own[1] == 0, "R8 release", sie_own[1], 0);
        check(port_addr(0) == 256, "R2 refused cfg", port_addr(0), 256);

        acc[1] = 1; commit[1] = 1; tick();
        check(sie_own[3] == 1, "R7 commit", sie_own[3], 1);
        check(port_addr(1) == 384, "R7 offset", port_addr(1), 384);
        sie_done[3] = 1; tick();

        sel(2, 1); tick();
        check(ready[2] == 0, "R9 shadowed", ready[2], 0);
        access(2, 1);
        check(err[2] == 1, "R10 shadowed access", err[2], 1);

        access(0, 2);
        sel(0, 7); acc[0] = 1; tick();
        check(port_addr(0) == 0, "R4 sel with access", port_addr(0), 0);
        check(ready[2] == 1, "R9 unshadowed", ready[2], 1);
        access(2, 3);
        check(port_addr(2) == 259, "R5 port2", port_addr(2), 259);
        sel(2, 1); tick();
        check(port_addr(2) == 256, "R4 reselect", port_addr(2), 256);
        check(err == 3'b101, "R10 sticky", err, 5);

        cfg(1, 30, 0);
        check(port_addr(2) == 1920, "R2 cfg accepted", port_addr(2), 1920);
        tick();

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule